// File: doc/BRIEF.md
# Lookup-Table Distributed RAM, 16 Words by 4 Bits

This block is a small random-access memory made from lookup-table cells grouped into storage slices. Each storage slice holds a 2-bit lane of every word, one lookup-table column per bit. With the default parameters, two storage slices give 16 words of 4 bits. A separate write-control stage turns the write strobe and the write address into one enable per word. That enable is shared by all storage slices.

Writes are synchronous to the rising clock edge. They use their own write address. Reads are purely combinational from an independent read address, so the memory behaves as one write port plus one asynchronous read port. A read at the address being written returns the stored word until the clock edge, and the freshly written word right after it. An active-low asynchronous reset clears every word to zero, so behaviour is deterministic from the start.

Top module: `lut_dram`

## Requirements
- R1: While `rst_n` is low, every word reads as zero. After reset is released, every word still reads zero until it is written.
- R2: On a rising `clk` edge with `wr_strobe` high, `wr_data` is stored at `wr_addr`. It is visible on `rd_data` as soon as `rd_addr` equals that address after the edge.
- R3: On a rising edge with `wr_strobe` low, no word changes.
- R4: `rd_data` follows `rd_addr` combinationally within the same cycle, with no clock edge needed.
- R5: When `rd_addr` equals `wr_addr` during a write cycle, `rd_data` shows the old word before the edge and the new word after it.
- R6: A write changes only the addressed word; every other address keeps its contents.
- R7: Bit k of `rd_data` returns bit k of the written word. Bits 1:0 live in storage slice 0 and bits 3:2 in storage slice 1, and neither lane disturbs the other.
- R8: Read and write addresses are independent. Reading one address while a different address is written returns the read address's own contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low clear of all words |
| wr_strobe | input | 1 | Write enable, sampled on the rising edge |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 4 | Write data word |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 4 | Combinational read data |

## Verification
A write becomes visible exactly one edge after it is presented. A read is due within the same cycle, with no edge at all. Inputs are driven on the falling edge. The read is checked 1 ns later, which still sees the pre-edge contents for the collision case. After the next rising edge, the read is checked again 1 ns later against the bench model, which is updated only at that edge. The bench therefore always samples between the register update and the next input change.

// File: rtl/lut_dram_pkg.sv
package lut_dram_pkg;
   localparam int DEF_ADDR_W = 4;
   localparam int DEF_DATA_W = 4;
   localparam int DEF_LANES  = 2;

   function automatic int depth_of(input int aw);
      return 1 << aw;
   endfunction
endpackage

// File: rtl/lut_dram_wdec.sv
module lut_dram_wdec #(
   parameter int ADDR_W = 4,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              wr_strobe,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [DEPTH-1:0]  word_we
);
   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      assign word_we[w] = wr_strobe && (wr_addr == ADDR_W'(w));
   end
endmodule

// File: rtl/lut_dram_col.sv
module lut_dram_col #(
   parameter int ADDR_W = 4,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DEPTH-1:0]  word_we,
   input  logic              din,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              dout
);
   logic [DEPTH-1:0] cells;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells <= '0;
      end else begin
         for (int w = 0; w < DEPTH; w++) begin
            if (word_we[w]) cells[w] <= din;
         end
      end
   end

   assign dout = cells[rd_addr];
endmodule

// File: rtl/lut_dram_slice.sv
module lut_dram_slice #(
   parameter int ADDR_W = 4,
   parameter int LANES  = 2,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DEPTH-1:0]  word_we,
   input  logic [LANES-1:0]  din,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [LANES-1:0]  dout
);
   for (genvar b = 0; b < LANES; b++) begin : g_col
      lut_dram_col #(.ADDR_W(ADDR_W)) u_col (
         .clk     (clk),
         .rst_n   (rst_n),
         .word_we (word_we),
         .din     (din[b]),
         .rd_addr (rd_addr),
         .dout    (dout[b])
      );
   end
endmodule

// File: rtl/lut_dram.sv
module lut_dram
   import lut_dram_pkg::*;
#(
   parameter int ADDR_W = DEF_ADDR_W,
   parameter int DATA_W = DEF_DATA_W,
   parameter int LANES  = DEF_LANES,
   localparam int DEPTH  = 1 << ADDR_W,
   localparam int SLICES = DATA_W / LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_strobe,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("lut_dram: ADDR_W must lie in 1..8");
   end
   if (LANES < 1 || DATA_W < LANES || (DATA_W % LANES) != 0) begin : g_bad_lanes
      $error("lut_dram: DATA_W must be a positive multiple of LANES");
   end
   if (depth_of(ADDR_W) != DEPTH) begin : g_bad_depth
      $error("lut_dram: depth mismatch");
   end

   logic [DEPTH-1:0] word_we;

   lut_dram_wdec #(.ADDR_W(ADDR_W)) u_wdec (
      .wr_strobe (wr_strobe),
      .wr_addr   (wr_addr),
      .word_we   (word_we)
   );

   for (genvar s = 0; s < SLICES; s++) begin : g_slice
      lut_dram_slice #(.ADDR_W(ADDR_W), .LANES(LANES)) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .word_we (word_we),
         .din     (wr_data[s*LANES +: LANES]),
         .rd_addr (rd_addr),
         .dout    (rd_data[s*LANES +: LANES])
      );
   end
endmodule

// File: rtl/lut_dram_chk.sv
module lut_dram_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_strobe,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data
);
   AST_RESET_CLEARS: assert property (@(posedge clk)
      (!rst_n && $past(!rst_n)) |-> (rd_data == '0)); // R1

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_strobe) && rd_addr == $past(wr_addr))
      |-> (rd_data == $past(wr_data))); // R2

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wr_strobe) && $stable(rd_addr))
      |-> $stable(rd_data)); // R3

   AST_OTHER_WORDS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_strobe) && $stable(rd_addr) && rd_addr != $past(wr_addr))
      |-> $stable(rd_data)); // R6
endmodule

bind lut_dram lut_dram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_strobe (wr_strobe),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .rd_addr   (rd_addr),
   .rd_data   (rd_data)
);

// File: tb/sim_lut_dram.sv
`timescale 1ns/1ps
module sim_lut_dram;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DW = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_strobe = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;

   int total = 0;
   int bad = 0;
   logic [DW-1:0] model [DEPTH];

   lut_dram u0 (
      .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
      return model[a];
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: rd_data=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // Drive on falling edge, check pre-edge read, then post-edge read.
   task automatic cycle(input logic we, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd, input logic [AW-1:0] ra,
                        input string req);
      @(negedge clk);
      wr_strobe = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
      #1;
      check({req, "/R4 pre-edge"}, rd_data, expect_word(ra));
      @(posedge clk);
      if (we) model[wa] = wd;
      #1;
      check(req, rd_data, expect_word(ra));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      summary();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      void'($urandom(32'd20240611));
      // R1: during reset
      #1;
      rd_addr = 4'd7; #1;
      check("R1 in reset", rd_data, 4'h0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: every word zero after release
      for (int a = 0; a < DEPTH; a++) begin
         rd_addr = AW'(a); #1;
         check("R1 after reset", rd_data, 4'h0);
      end
      // R2: boundaries
      cycle(1'b1, 4'd0, 4'hA, 4'd0, "R2 addr0");
      cycle(1'b1, 4'd15, 4'h5, 4'd15, "R2 addr15");
      // R3: strobe low, data ignored
      cycle(1'b0, 4'd0, 4'hF, 4'd0, "R3 no write");
      // R5: collision, old then new
      cycle(1'b1, 4'd5, 4'h3, 4'd5, "R5 collision first");
      cycle(1'b1, 4'd5, 4'hC, 4'd5, "R5 collision second");
      // R7: lane separation
      cycle(1'b1, 4'd9, 4'b0011, 4'd9, "R7 low lane");
      cycle(1'b1, 4'd10, 4'b1100, 4'd10, "R7 high lane");
      cycle(1'b0, 4'd0, 4'h0, 4'd9, "R7 low lane readback");
      // R8 / R6: read other address during a write
      cycle(1'b1, 4'd3, 4'h7, 4'd15, "R8 independent read");
      cycle(1'b0, 4'd0, 4'h0, 4'd3, "R6 written word");
      // R4: address change within a cycle, no edge
      @(negedge clk);
      wr_strobe = 1'b0;
      rd_addr = 4'd0; #1; check("R4 comb read a0", rd_data, expect_word(4'd0));
      rd_addr = 4'd10; #1; check("R4 comb read a10", rd_data, expect_word(4'd10));
      // R6: random writes, every word scanned
      for (int n = 0; n < 400; n++) begin
         cycle(1'($urandom_range(0, 1)), AW'($urandom_range(0, DEPTH-1)),
               DW'($urandom_range(0, (1<<DW)-1)), AW'($urandom_range(0, DEPTH-1)),
               "R6 random");
      end
      for (int a = 0; a < DEPTH; a++) begin
         cycle(1'b0, 4'd0, 4'h0, AW'(a), "R6 final scan");
      end
      summary();
   end
endmodule